// File: doc/BRIEF.md
# Frame and Channel Position Timer

This block keeps track of where a framed serial stream currently sits, one clock per bit. It serves two stream formats. At the slower rate a frame has 193 bit slots: one overhead (framing) slot comes first, then 24 channels of 8 bits. At the faster rate a frame has 256 bit slots, which are 32 channels of 8 bits with no overhead slot. Both formats repeat at 8 kHz. A static select input chooses the format.

A rising edge on the frame sync input puts the counter at the start of a frame. The sync input does not have to pulse every frame. After one edge the counter keeps running frame after frame on its own, and any later rising edge moves it back to the frame start. From the counter the block decodes these outputs:
- the bit index within the frame;
- the channel index;
- the bit position within the channel;
- a strobe at the frame start;
- a flag for the overhead slot;
- a channel clock that rises at every channel boundary.

Storage and slip logic on the same side of the interface use these outputs to know the position of the stream.

Top module: `ftg_frame_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, bit_idx is 0 and frame_start is 1. With rate_sel=0 in that state, framing_bit is 1 and chan_clk is 0.
- R2: When fsync is sampled high at a clock edge and was sampled low at the previous edge, bit_idx is 0 after that edge.
- R3: With rate_sel=0 and no sync edge, bit_idx increases by 1 each clock and wraps from 192 to 0. The frame is 193 slots long.
- R4: With rate_sel=1 and no sync edge, bit_idx increases by 1 each clock and wraps from 255 to 0. The frame is 256 slots long, and the counter keeps this timing over several frames without any sync.
- R5: A sync input held high realigns the counter only once, at its rising edge. While the level stays high the counter keeps counting. The sync register resets to 1, so a sync input that is high as reset is released is not treated as an edge.
- R6: A rising edge of fsync in the middle of a frame moves bit_idx to 0, whatever position the counter had reached.
- R7: frame_start is 1 exactly in the cycles where bit_idx is 0.
- R8: With rate_sel=0, slot 0 is the overhead slot. In that slot framing_bit=1, chan_idx=0, chan_bit=0 and chan_clk=0. For slots b from 1 to 192, chan_idx=(b-1)/8 and chan_bit=(b-1)%8.
- R9: With rate_sel=1, framing_bit is always 0, chan_idx=b/8 and chan_bit=b%8.
- R10: chan_clk is 1 in a channel slot whose chan_bit is below 4, and 0 otherwise. It therefore rises only where chan_bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock of this side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rate_sel | input | 1 | Static format select: 0 = 193-slot frame, 1 = 256-slot frame |
| fsync | input | 1 | Frame sync; its rising edge marks a frame start |
| bit_idx | output | 8 | Bit slot within the frame |
| chan_idx | output | 5 | Channel number of the current slot |
| chan_bit | output | 3 | Bit position within the channel |
| frame_start | output | 1 | High in slot 0 of the frame |
| framing_bit | output | 1 | High in the overhead slot (193-slot format only) |
| chan_clk | output | 1 | Channel clock: high for the first half of each channel |

## Verification
On every cycle the assertions check how the counter moves: it goes to zero after a sync edge, steps by one, and wraps at the length set by the current format. They also check that the channel clock rises only at a channel's first bit, that the overhead slot never carries channel data, and that the frame strobe lasts one cycle when no sync edge arrives. Only the bench scenarios can show the complete decode of every slot in both formats. The same holds for holding position over several frames with no sync, for a realignment in mid-frame, and for a sync level held high over many cycles.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  parameter int CHAN_BITS   = 8;
  parameter int SLOW_CHANS  = 24;
  parameter int FAST_CHANS  = 32;
  parameter int SLOW_OVH    = 1;

  localparam int SLOW_LEN   = SLOW_OVH + SLOW_CHANS * CHAN_BITS;
  localparam int FAST_LEN   = FAST_CHANS * CHAN_BITS;
  localparam int MAX_LEN    = (SLOW_LEN > FAST_LEN) ? SLOW_LEN : FAST_LEN;
  localparam int CNT_W      = $clog2(MAX_LEN);
  localparam int CB_W       = $clog2(CHAN_BITS);
  localparam int CH_W       = CNT_W - CB_W;
endpackage

// File: rtl/ftg_edge_det.sv
module ftg_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic edge_o
);
  logic sync_q;
  logic sync_d;

  always_comb begin
    sync_d = sync_in;
    edge_o = sync_in & ~sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b1;
    else        sync_q <= sync_d;
  end

  // R5
  level_noedge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (sync_in ? !edge_o : 1'b1));
endmodule

// File: rtl/ftg_bit_counter.sv
module ftg_bit_counter
  import ftg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast_mode,
  input  logic             load,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_LEN - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = fast_mode ? FAST_LAST : SLOW_LAST;
    if (load)               cnt_d = '0;
    else if (cnt_q >= last) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2
  load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q < last && $stable(fast_mode)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == last) |=> (cnt_q == '0));
endmodule

// File: rtl/ftg_pos_decode.sv
module ftg_pos_decode
  import ftg_pkg::*;
(
  input  logic             fast_mode,
  input  logic [CNT_W-1:0] cnt,
  output logic [CH_W-1:0]  chan_o,
  output logic [CB_W-1:0]  cbit_o,
  output logic             fstart_o,
  output logic             ovh_o,
  output logic             chclk_o
);
  localparam logic [CNT_W-1:0] OVH_OFS = CNT_W'(SLOW_OVH);
  localparam int               HALF    = CHAN_BITS / 2;

  logic [CNT_W-1:0] pos;

  always_comb begin
    ovh_o    = !fast_mode && (cnt < OVH_OFS);
    pos      = fast_mode ? cnt : (cnt - OVH_OFS);
    fstart_o = (cnt == '0);
    if (ovh_o) begin
      chan_o  = '0;
      cbit_o  = '0;
      chclk_o = 1'b0;
    end else begin
      chan_o  = pos[CNT_W-1:CB_W];
      cbit_o  = pos[CB_W-1:0];
      chclk_o = (int'(pos[CB_W-1:0]) < HALF);
    end
  end
endmodule

// File: rtl/ftg_frame_timer.sv
module ftg_frame_timer
  import ftg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_sel,
  input  logic             fsync,
  output logic [CNT_W-1:0] bit_idx,
  output logic [CH_W-1:0]  chan_idx,
  output logic [CB_W-1:0]  chan_bit,
  output logic             frame_start,
  output logic             framing_bit,
  output logic             chan_clk
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       sync_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ftg_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sync_in (fsync),
    .edge_o  (sync_edge)
  );

  ftg_bit_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fast_mode (rate_sel),
    .load      (sync_edge),
    .cnt_o     (bit_idx)
  );

  ftg_pos_decode u_dec (
    .fast_mode (rate_sel),
    .cnt       (bit_idx),
    .chan_o    (chan_idx),
    .cbit_o    (chan_bit),
    .fstart_o  (frame_start),
    .ovh_o     (framing_bit),
    .chclk_o   (chan_clk)
  );

  // R10
  chclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(chan_clk) && $stable(rate_sel)) |-> (chan_bit == '0));
  // R8
  ovh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    framing_bit |-> (!chan_clk && chan_idx == '0 && !rate_sel));
  // R7
  fstart_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (frame_start && !sync_edge) |=> !frame_start);
endmodule

// File: tb/sim_ftg_frame_timer.sv
module sim_ftg_frame_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rate_sel;
  logic       fsync;
  logic [7:0] bit_idx;
  logic [4:0] chan_idx;
  logic [2:0] chan_bit;
  logic       frame_start, framing_bit, chan_clk;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ftg_frame_timer u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .fsync(fsync),
    .bit_idx(bit_idx), .chan_idx(chan_idx), .chan_bit(chan_bit),
    .frame_start(frame_start), .framing_bit(framing_bit), .chan_clk(chan_clk)
  );

  task automatic check_slot(input string req, input int b);
    logic [7:0] e_ch, e_bit;
    logic       e_fr, e_fs, e_clk;
    int p;
    e_fs = (b == 0);
    if (!rate_sel && b == 0) begin
      e_fr = 1; e_ch = 0; e_bit = 0; e_clk = 0;
    end else begin
      p = rate_sel ? b : b - 1;
      e_fr = 0; e_ch = 8'(p / 8); e_bit = 8'(p % 8); e_clk = (p % 8) < 4;
    end
    checks++;
    if (bit_idx !== 8'(b) || chan_idx !== e_ch[4:0] || chan_bit !== e_bit[2:0] ||
        frame_start !== e_fs || framing_bit !== e_fr || chan_clk !== e_clk) begin
      errors++;
      $display("FAIL %s: got idx=%0d ch=%0d cb=%0d fs=%0b fr=%0b cc=%0b exp idx=%0d ch=%0d cb=%0d fs=%0b fr=%0b cc=%0b",
               req, bit_idx, chan_idx, chan_bit, frame_start, framing_bit, chan_clk,
               b, e_ch, e_bit, e_fs, e_fr, e_clk);
    end
  endtask

  task automatic align();
    @(negedge clk) fsync = 1'b1;
    @(negedge clk) fsync = 1'b0;
  endtask

  task automatic t_reset();
    rate_sel = 1'b0; fsync = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_slot("R1 in reset", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_slot("R1 after release", 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_sweep(input logic fast);
    int len;
    rate_sel = fast;
    len = fast ? 256 : 193;
    align();
    check_slot("R2 align", 0);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      check_slot(fast ? "R4 R9 R10 R7 sweep" : "R3 R8 R10 R7 sweep", k % len);
    end
  endtask

  task automatic t_flywheel();
    int starts;
    rate_sel = 1'b1;
    align();
    starts = 0;
    for (int k = 1; k <= 3 * 256; k++) begin
      @(negedge clk);
      if (frame_start) starts++;
    end
    check_slot("R4 flywheel", 0);
    checks++;
    if (starts != 3) begin
      errors++;
      $display("FAIL R4 flywheel strobes: got %0d exp 3", starts);
    end
  endtask

  task automatic t_realign();
    rate_sel = 1'b0;
    align();
    repeat (50) @(negedge clk);
    check_slot("R6 before realign", 50);
    align();
    check_slot("R6 realign", 0);
    @(negedge clk);
    check_slot("R6 after realign", 1);
  endtask

  task automatic t_level();
    rate_sel = 1'b1;
    @(negedge clk) fsync = 1'b1;
    @(negedge clk);
    check_slot("R5 edge", 0);
    repeat (20) @(negedge clk);
    check_slot("R5 held level", 20);
    fsync = 1'b0;
    @(negedge clk);
    check_slot("R5 level drop", 21);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_flywheel();
    t_realign();
    t_level();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule